// File: doc/BRIEF.md
# SCSI Controller Interrupt Aggregator

This block gathers interrupt conditions from the two halves of a SCSI host controller. The DMA engine and the bus-side logic each report their conditions as set pulses. The block keeps those conditions in three sticky status bytes: one for DMA and two for the SCSI side. It combines the status with three enable bytes and drives a single level-sensitive interrupt line. It also produces two summary pending flags, one for each side.

The block also judges every new condition against the script sequencer. Any DMA condition requests a halt. A SCSI condition requests a halt depending on its class:
- A few routine SCSI conditions halt only when they are enabled.
- A selection timeout never halts.
- Every other SCSI condition halts unconditionally.

A software flag forces the interrupt line high whatever the masks hold. Status bits are removed only through explicit write-one-to-clear inputs.

Top module: `scsi_irq_aggregator`

## Requirements
- R1: While `rst` is high at a clock edge, the edge clears all status bytes and all enable bytes. It also drives `irq`, `dma_pend`, `scsi_pend` and `halt_req` low.
- R2: At each edge, each status byte becomes (old & ~clear) | set. Set bits stay until cleared. A bit both set and cleared in the same cycle ends up set.
- R3: `dma_pend` equals the OR of all DMA status bits as they stood one cycle earlier.
- R4: `scsi_pend` is high one cycle after either SCSI status byte is nonzero. It is low one cycle after both bytes are zero.
- R5: `irq` is high one cycle after (DMA status & DMA enable) is nonzero, or after (either SCSI status byte & its own enable byte) is nonzero.
- R6: While `force_irq` is high at an edge, `irq` is high after that edge, whatever the status and enable bytes hold.
- R7: An enable write lands at the edge where its write strobe is high. `irq` reflects the new enable byte one edge later.
- R8: A cycle with any nonzero bit on `dma_set` makes `halt_req` high for the following cycle.
- R9: SCSI byte-0 bits 6, 5 and 4 (mask 0x70) request a halt only when their own enable bit is set. SCSI byte-1 bits 1 and 0 (mask 0x03) follow the same rule.
- R10: SCSI byte-1 bit 2 (0x04, selection timeout) never requests a halt, even when enabled.
- R11: All other SCSI status bits request a halt whatever the enables hold. The halt check runs in each cycle with any nonzero SCSI set bit, and it looks at the full updated status, not only the new bits.
- R12: `halt_req` is low after any cycle that has no nonzero set bit on any of the three set inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_set | input | 8 | DMA condition set pulses |
| dma_clr | input | 8 | DMA status write-one-to-clear |
| dma_en_we | input | 1 | DMA enable write strobe |
| dma_en_wdata | input | 8 | DMA enable write data |
| scsi0_set | input | 8 | SCSI byte-0 condition set pulses |
| scsi0_clr | input | 8 | SCSI byte-0 write-one-to-clear |
| scsi0_en_we | input | 1 | SCSI byte-0 enable write strobe |
| scsi0_en_wdata | input | 8 | SCSI byte-0 enable write data |
| scsi1_set | input | 8 | SCSI byte-1 condition set pulses |
| scsi1_clr | input | 8 | SCSI byte-1 write-one-to-clear |
| scsi1_en_we | input | 1 | SCSI byte-1 enable write strobe |
| scsi1_en_wdata | input | 8 | SCSI byte-1 enable write data |
| force_irq | input | 1 | Software interrupt-forcing flag |
| irq | output | 1 | Registered interrupt line |
| dma_pend | output | 1 | DMA-side pending summary |
| scsi_pend | output | 1 | SCSI-side pending summary |
| halt_req | output | 1 | One-cycle sequencer halt request |
| dma_status | output | 8 | DMA status byte |
| scsi0_status | output | 8 | SCSI status byte 0 |
| scsi1_status | output | 8 | SCSI status byte 1 |

## Verification
A new condition's halt decision and the settling of its pending and interrupt outputs fall one cycle apart. The bench checks both sides of that gap for each bit: it samples `halt_req` right after the setting edge and samples `irq`/`dma_pend`/`scsi_pend` one edge later. The halt test sweeps every bit of every status byte with its enable both clear and set. It is judged against a halt rule computed arithmetically in the bench. The bench also collides a set with a clear of the same bit in one cycle, and an enable write with a pending status.

// File: rtl/scsi_irq_pkg.sv
package scsi_irq_pkg;

    localparam int STAT_W  = 8;
    localparam int NUM_SRC = 3;
    localparam int SRC_IDX_W = $clog2(NUM_SRC);

    typedef logic [STAT_W-1:0] stat_t;

    typedef enum logic [SRC_IDX_W-1:0] {
        SRC_DMA   = 2'd0,
        SRC_SCSI0 = 2'd1,
        SRC_SCSI1 = 2'd2
    } src_e;

    // SCSI conditions that halt only when enabled
    localparam stat_t SCSI0_SOFT_BITS = 8'h70;
    localparam stat_t SCSI1_SOFT_BITS = 8'h03;
    // SCSI conditions that never halt
    localparam stat_t SCSI1_NOHALT_BITS = 8'h04;

    typedef struct packed {
        stat_t set;
        stat_t clr;
        logic  en_we;
        stat_t en_wdata;
    } src_req_t;

    typedef struct packed {
        stat_t stat;
        stat_t stat_nxt;
        stat_t en;
    } src_state_t;

    function automatic stat_t halt_mask_scsi0(stat_t en);
        return en | ~SCSI0_SOFT_BITS;
    endfunction

    function automatic stat_t halt_mask_scsi1(stat_t en);
        return (en | ~SCSI1_SOFT_BITS) & ~SCSI1_NOHALT_BITS;
    endfunction

    function automatic logic masked_any(stat_t a, stat_t b);
        return |(a & b);
    endfunction

endpackage

// File: rtl/sia_src_reg.sv
module sia_src_reg
    import scsi_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  src_req_t   req,
    output src_state_t st
);
    stat_t stat_q;
    stat_t en_q;
    stat_t stat_d;

    // set dominates clear in the same cycle
    always_comb begin
        stat_d = (stat_q & ~req.clr) | req.set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            stat_q <= stat_d;
            if (req.en_we) begin
                en_q <= req.en_wdata;
            end
        end
    end

    always_comb begin
        st.stat     = stat_q;
        st.stat_nxt = stat_d;
        st.en       = en_q;
    end
endmodule

// File: rtl/sia_halt_eval.sv
module sia_halt_eval
    import scsi_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  stat_t dma_set,
    input  stat_t scsi0_set,
    input  stat_t scsi1_set,
    input  stat_t scsi0_nxt,
    input  stat_t scsi1_nxt,
    input  stat_t scsi0_en,
    input  stat_t scsi1_en,
    output logic  halt_req
);
    logic dma_evt;
    logic scsi_evt;
    logic scsi_halt;
    logic halt_d;
    logic halt_q;

    always_comb begin
        dma_evt   = |dma_set;
        scsi_evt  = (|scsi0_set) | (|scsi1_set);
        scsi_halt = masked_any(scsi0_nxt, halt_mask_scsi0(scsi0_en)) |
                    masked_any(scsi1_nxt, halt_mask_scsi1(scsi1_en));
        halt_d    = dma_evt | (scsi_evt & scsi_halt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q <= 1'b0;
        end else begin
            halt_q <= halt_d;
        end
    end

    assign halt_req = halt_q;
endmodule

// File: rtl/sia_irq_gen.sv
module sia_irq_gen
    import scsi_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  stat_t stat [NUM_SRC],
    input  stat_t en   [NUM_SRC],
    input  logic  force_flag,
    output logic  irq,
    output logic  dma_pend,
    output logic  scsi_pend
);
    logic [NUM_SRC-1:0] src_any;
    logic [NUM_SRC-1:0] src_hit;
    logic irq_q, dpend_q, spend_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign src_any[g] = |stat[g];
        assign src_hit[g] = masked_any(stat[g], en[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q   <= 1'b0;
            dpend_q <= 1'b0;
            spend_q <= 1'b0;
        end else begin
            irq_q   <= (|src_hit) | force_flag;
            dpend_q <= src_any[SRC_DMA];
            spend_q <= src_any[SRC_SCSI0] | src_any[SRC_SCSI1];
        end
    end

    assign irq       = irq_q;
    assign dma_pend  = dpend_q;
    assign scsi_pend = spend_q;
endmodule

// File: rtl/scsi_irq_aggregator.sv
module scsi_irq_aggregator
    import scsi_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] dma_set,
    input  logic [7:0] dma_clr,
    input  logic       dma_en_we,
    input  logic [7:0] dma_en_wdata,
    input  logic [7:0] scsi0_set,
    input  logic [7:0] scsi0_clr,
    input  logic       scsi0_en_we,
    input  logic [7:0] scsi0_en_wdata,
    input  logic [7:0] scsi1_set,
    input  logic [7:0] scsi1_clr,
    input  logic       scsi1_en_we,
    input  logic [7:0] scsi1_en_wdata,
    input  logic       force_irq,
    output logic       irq,
    output logic       dma_pend,
    output logic       scsi_pend,
    output logic       halt_req,
    output logic [7:0] dma_status,
    output logic [7:0] scsi0_status,
    output logic [7:0] scsi1_status
);
    src_req_t   req_a  [NUM_SRC];
    src_state_t st_a   [NUM_SRC];
    stat_t      stat_a [NUM_SRC];
    stat_t      en_a   [NUM_SRC];

    always_comb begin
        req_a[SRC_DMA]   = '{set: dma_set,   clr: dma_clr,   en_we: dma_en_we,   en_wdata: dma_en_wdata};
        req_a[SRC_SCSI0] = '{set: scsi0_set, clr: scsi0_clr, en_we: scsi0_en_we, en_wdata: scsi0_en_wdata};
        req_a[SRC_SCSI1] = '{set: scsi1_set, clr: scsi1_clr, en_we: scsi1_en_we, en_wdata: scsi1_en_wdata};
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        sia_src_reg u_reg (
            .clk (clk),
            .rst (rst),
            .req (req_a[g]),
            .st  (st_a[g])
        );
        assign stat_a[g] = st_a[g].stat;
        assign en_a[g]   = st_a[g].en;
    end

    sia_halt_eval u_halt (
        .clk       (clk),
        .rst       (rst),
        .dma_set   (dma_set),
        .scsi0_set (scsi0_set),
        .scsi1_set (scsi1_set),
        .scsi0_nxt (st_a[SRC_SCSI0].stat_nxt),
        .scsi1_nxt (st_a[SRC_SCSI1].stat_nxt),
        .scsi0_en  (st_a[SRC_SCSI0].en),
        .scsi1_en  (st_a[SRC_SCSI1].en),
        .halt_req  (halt_req)
    );

    sia_irq_gen u_irq (
        .clk        (clk),
        .rst        (rst),
        .stat       (stat_a),
        .en         (en_a),
        .force_flag (force_irq),
        .irq        (irq),
        .dma_pend   (dma_pend),
        .scsi_pend  (scsi_pend)
    );

    assign dma_status   = st_a[SRC_DMA].stat;
    assign scsi0_status = st_a[SRC_SCSI0].stat;
    assign scsi1_status = st_a[SRC_SCSI1].stat;
endmodule

// File: rtl/sia_chk.sv
module sia_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] dma_set,
    input logic [7:0] dma_clr,
    input logic [7:0] scsi0_set,
    input logic [7:0] scsi1_set,
    input logic       force_irq,
    input logic       irq,
    input logic       dma_pend,
    input logic       scsi_pend,
    input logic       halt_req,
    input logic [7:0] dma_status,
    input logic [7:0] scsi0_status,
    input logic [7:0] scsi1_status
);
    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && !dma_pend && !scsi_pend && !halt_req && dma_status == 8'h00));

    // R2
    sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((dma_status & $past(dma_set)) == $past(dma_set)));

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((dma_status & $past(dma_status & ~dma_clr)) == $past(dma_status & ~dma_clr)));

    // R3
    dma_pend_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (dma_pend == $past(|dma_status)));

    // R4
    scsi_pend_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (scsi_pend == $past((|scsi0_status) | (|scsi1_status))));

    // R6
    force_chk: assert property (@(posedge clk) disable iff (rst)
        force_irq |=> irq);

    // R8
    dma_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (|dma_set) |=> halt_req);

    // R12
    no_event_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_set == 8'h00 && scsi0_set == 8'h00 && scsi1_set == 8'h00) |=> !halt_req);
endmodule

bind scsi_irq_aggregator sia_chk u_chk (.*);

// File: tb/scsi_irq_aggregator_tb_top.sv
module scsi_irq_aggregator_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] dma_set = '0, dma_clr = '0, dma_en_wdata = '0;
    logic [7:0] scsi0_set = '0, scsi0_clr = '0, scsi0_en_wdata = '0;
    logic [7:0] scsi1_set = '0, scsi1_clr = '0, scsi1_en_wdata = '0;
    logic dma_en_we = 1'b0, scsi0_en_we = 1'b0, scsi1_en_we = 1'b0;
    logic force_irq = 1'b0;
    logic irq, dma_pend, scsi_pend, halt_req;
    logic [7:0] dma_status, scsi0_status, scsi1_status;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    scsi_irq_aggregator dut_i (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        dma_clr = 8'hff; scsi0_clr = 8'hff; scsi1_clr = 8'hff;
        dma_en_we = 1; scsi0_en_we = 1; scsi1_en_we = 1;
        dma_en_wdata = 0; scsi0_en_wdata = 0; scsi1_en_wdata = 0;
        tick();
        dma_clr = 0; scsi0_clr = 0; scsi1_clr = 0;
        dma_en_we = 0; scsi0_en_we = 0; scsi1_en_we = 0;
        tick();
    endtask

    // expected halt from the requirement text
    function automatic logic exp_halt0(int b, logic en);
        if (b == 4 || b == 5 || b == 6) return en;
        return 1'b1;
    endfunction
    function automatic logic exp_halt1(int b, logic en);
        if (b == 2) return 1'b0;
        if (b == 0 || b == 1) return en;
        return 1'b1;
    endfunction

    initial begin
        repeat (3) tick();
        chk("R1 irq", irq, 0);
        chk("R1 halt", halt_req, 0);
        chk("R1 status", {dma_status, scsi0_status, scsi1_status}, 0);
        chk("R1 pend", {dma_pend, scsi_pend}, 0);
        rst = 0;
        tick();

        // sweep every bit of each byte, enable off and on
        for (int src = 0; src < 3; src++) begin
            for (int b = 0; b < 8; b++) begin
                for (int e = 0; e < 2; e++) begin
                    logic eh;
                    clear_all();
                    if (src == 0) begin dma_en_we = 1; dma_en_wdata = e ? (8'h1 << b) : 8'h0; end
                    if (src == 1) begin scsi0_en_we = 1; scsi0_en_wdata = e ? (8'h1 << b) : 8'h0; end
                    if (src == 2) begin scsi1_en_we = 1; scsi1_en_wdata = e ? (8'h1 << b) : 8'h0; end
                    tick();
                    dma_en_we = 0; scsi0_en_we = 0; scsi1_en_we = 0;
                    if (src == 0) dma_set = 8'h1 << b;
                    if (src == 1) scsi0_set = 8'h1 << b;
                    if (src == 2) scsi1_set = 8'h1 << b;
                    tick();
                    dma_set = 0; scsi0_set = 0; scsi1_set = 0;
                    eh = (src == 0) ? 1'b1 : (src == 1) ? exp_halt0(b, e[0]) : exp_halt1(b, e[0]);
                    if (src == 0) chk("R8 dma halt", halt_req, 1);
                    else if (src == 1 && (b >= 4 && b <= 6)) chk("R9 soft halt byte0", halt_req, eh);
                    else if (src == 2 && b < 2) chk("R9 soft halt byte1", halt_req, eh);
                    else if (src == 2 && b == 2) chk("R10 timeout no halt", halt_req, 0);
                    else chk("R11 hard halt", halt_req, eh);
                    chk("R2 status set", {dma_status, scsi0_status, scsi1_status},
                        32'(1) << (b + 8 * (2 - src)));
                    tick();
                    chk("R12 halt one cycle", halt_req, 0);
                    chk("R3 dma pend", dma_pend, src == 0);
                    chk("R4 scsi pend", scsi_pend, src != 0);
                    chk("R5 irq vs enable", irq, e);
                end
            end
        end

        // sticky accumulate and set-over-clear
        clear_all();
        dma_set = 8'h01; tick();
        dma_set = 8'h80; tick();
        dma_set = 0;
        chk("R2 accumulate", dma_status, 8'h81);
        dma_set = 8'h01; dma_clr = 8'h01; tick();
        dma_set = 0; dma_clr = 0;
        chk("R2 set wins", dma_status, 8'h81);
        dma_clr = 8'h81; tick();
        dma_clr = 0;
        chk("R2 cleared", dma_status, 8'h00);
        tick();
        chk("R3 pend drops", dma_pend, 0);

        // accumulated hard bit halts on a later soft event
        clear_all();
        scsi0_set = 8'h80; tick();
        scsi0_set = 8'h40; tick();
        scsi0_set = 0;
        chk("R11 accumulated halt", halt_req, 1);

        // enable write timing
        clear_all();
        dma_set = 8'h10; tick(); dma_set = 0;
        tick();
        chk("R5 masked", irq, 0);
        dma_en_we = 1; dma_en_wdata = 8'h10; tick(); dma_en_we = 0;
        chk("R7 not yet", irq, 0);
        tick();
        chk("R7 after write", irq, 1);
        scsi1_en_we = 1; scsi1_en_wdata = 8'hff; dma_en_we = 1; dma_en_wdata = 0; tick();
        scsi1_en_we = 0; dma_en_we = 0;
        tick();
        chk("R7 mask removed", irq, 0);

        // force flag
        clear_all();
        force_irq = 1; tick();
        chk("R6 force empty", irq, 1);
        force_irq = 0; tick();
        chk("R6 force released", irq, 0);

        // reset mid-run
        dma_set = 8'hff; dma_en_we = 1; dma_en_wdata = 8'hff; tick();
        dma_set = 0; dma_en_we = 0;
        rst = 1; tick(); rst = 0;
        chk("R1 reset status", dma_status, 0);
        chk("R1 reset irq", irq, 0);
        tick();
        chk("R1 enables cleared", irq, 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule